// File: doc/BRIEF.md
# Reference and PPS Source Control

This block holds the board's timing-source configuration and reports timing status to a host. A single 32-bit write port loads a small control register. That register picks the reference clock source and the one-pulse-per-second (PPS) source, and it drives three enables: PPS output, local oscillator and GPS module power. The selected clock source code goes straight out to the clock tree logic. The PPS source code steers a multiplexer over three pulse sources: an external pin, a GPS receiver pin and a pulse generated inside the block.

The external and GPS pulses arrive asynchronously and are brought into the clock domain before use. The internal pulse comes from a counter with a parameterised terminal count, normally the clock frequency in Hz. A 32-bit status word returns the PLL status, lock and holdover inputs, also synchronised. It also returns a PPS-detect bit that flips on every rising edge of the selected pulse. Software proves a live PPS by reading the bit twice and seeing it change. The bit does not latch.

Top module: `refpps_ctrl`

## Requirements
- R1: After reset, the clock select output and the PPS select output are both 2 (internal). The PPS output is 0, the oscillator enable is 1 and GPS power is 1.
- R2: On a clock edge with `wr_en` high, the control fields load from `wr_data`: [1:0] clock source, [3:2] PPS source, bit 4 PPS output enable, bit 5 oscillator enable, bit 6 GPS power. The outputs show the new values right after that edge. Bits [31:7] of `wr_data` have no effect.
- R3: The PPS select code picks the source: 0 selects the external input, 2 the internal pulse and 3 the GPS input. The clock select uses the same codes and is passed out unchanged.
- R4: PPS select code 1 is reserved. While it is in force, the selected PPS is low, `pps_out` is low and the detect bit does not change.
- R5: `rd_data[1:0]` return `pll_stat_in`, bit 2 returns `pll_lock_in` and bit 3 returns `pll_hold_in`. Each passes through a two-flop synchroniser, so a change shows two edges later. `rd_data[31:5]` are 0.
- R6: `rd_data[4]` is 0 after reset. It inverts one edge after each rising edge of the selected, synchronised PPS, and it holds its value when no edge arrives. A rising edge caused by a change of select also counts.
- R7: When the PPS output enable is set, `pps_out` equals the selected, synchronised PPS. Otherwise `pps_out` is 0.
- R8: `pps_int` is high for exactly one cycle every `PPS_TERM` cycles. The first pulse follows the `PPS_TERM`-th clock edge after reset.
- R9: A change on `pps_ext_in` or `pps_gps_in` reaches the selected PPS two clock edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Status word |
| pll_stat_in | input | 2 | PLL status pins (asynchronous) |
| pll_lock_in | input | 1 | PLL lock pin (asynchronous) |
| pll_hold_in | input | 1 | PLL holdover pin (asynchronous) |
| pps_ext_in | input | 1 | External PPS (asynchronous) |
| pps_gps_in | input | 1 | GPS receiver PPS (asynchronous) |
| clk_sel | output | 2 | Reference clock source code |
| pps_sel | output | 2 | PPS source code |
| pps_out | output | 1 | Gated selected PPS |
| osc_en | output | 1 | Local oscillator enable |
| gps_pwr | output | 1 | GPS module power enable |
| pps_int | output | 1 | Internal one-cycle PPS pulse |

## Verification
A register write that changes the PPS source can land in the same cycle as a pulse edge. If the new source is already high while the old one was low, the switch itself counts as a rising edge. The bench holds the GPS input high while the external source is selected, then writes the GPS code. It also writes a new select in the same cycle that an external edge emerges from the synchroniser. A behavioural model compares the result on every cycle. That model keeps sample histories in queues and applies the write and the edge rule in the order the requirements state.

// File: rtl/refpps_pkg.sv
package refpps_pkg;
  localparam logic [1:0] SRC_EXT  = 2'd0;
  localparam logic [1:0] SRC_RSVD = 2'd1;
  localparam logic [1:0] SRC_INT  = 2'd2;
  localparam logic [1:0] SRC_GPS  = 2'd3;

  localparam int CTRL_W = 7;
  localparam int STAT_W = 4;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic       gps_pwr;
    logic       osc_en;
    logic       pps_oe;
    logic [1:0] pps_src;
    logic [1:0] clk_src;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{gps_pwr: 1'b1, osc_en: 1'b1, pps_oe: 1'b0,
                                 pps_src: SRC_INT, clk_src: SRC_INT};
endpackage

// File: rtl/refpps_sync.sv
module refpps_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_in;
      stab_q <= meta_q;
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/refpps_tick.sv
module refpps_tick #(
  parameter int TERM = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TERM > 1) ? $clog2(TERM) : 1;
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == LAST);
    cnt_d  = wrap ? '0 : cnt_q + 1'b1;
    tick_d = wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

  generate
    if (TERM > 1) begin : g_chk
      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q); // R8
    end
  endgenerate
endmodule

// File: rtl/refpps_route.sv
module refpps_route
  import refpps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src,
  input  logic       ext_s,
  input  logic       int_p,
  input  logic       gps_s,
  output logic       pps_sel_o,
  output logic       det
);
  logic mux;
  logic prev_q, prev_d;
  logic det_q, det_d;

  always_comb begin
    unique case (src)
      SRC_EXT: mux = ext_s;
      SRC_INT: mux = int_p;
      SRC_GPS: mux = gps_s;
      default: mux = 1'b0;
    endcase
    prev_d = mux;
    det_d  = det_q ^ (mux & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      det_q  <= det_d;
    end
  end

  assign pps_sel_o = mux;
  assign det       = det_q;

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_RSVD) |=> $stable(det_q)); // R4
  AST_DET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q != $past(det_q)) |-> $past(pps_sel_o && !prev_q)); // R6
endmodule

// File: rtl/refpps_ctrl.sv
module refpps_ctrl
  import refpps_pkg::*;
#(
  parameter int PPS_TERM = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [1:0]  pll_stat_in,
  input  logic        pll_lock_in,
  input  logic        pll_hold_in,
  input  logic        pps_ext_in,
  input  logic        pps_gps_in,
  output logic [1:0]  clk_sel,
  output logic [1:0]  pps_sel,
  output logic        pps_out,
  output logic        osc_en,
  output logic        gps_pwr,
  output logic        pps_int
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [STAT_W-1:0] stat_s;
  logic [1:0]        pin_s;
  logic              tick;
  logic              pps_mux;
  logic              det;
  logic              unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= CTRL_RST;
    else        ctrl_q <= ctrl_d;
  end

  refpps_sync #(.W(STAT_W)) u_stat_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({pll_hold_in, pll_lock_in, pll_stat_in}),
    .sync_out(stat_s)
  );

  refpps_sync #(.W(2)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({pps_gps_in, pps_ext_in}),
    .sync_out(pin_s)
  );

  refpps_tick #(.TERM(PPS_TERM)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  refpps_route u_route (
    .clk(clk), .rst_n(rst_n),
    .src(ctrl_q.pps_src),
    .ext_s(pin_s[0]), .int_p(tick), .gps_s(pin_s[1]),
    .pps_sel_o(pps_mux), .det(det)
  );

  assign clk_sel = ctrl_q.clk_src;
  assign pps_sel = ctrl_q.pps_src;
  assign osc_en  = ctrl_q.osc_en;
  assign gps_pwr = ctrl_q.gps_pwr;
  assign pps_out = ctrl_q.pps_oe & pps_mux;
  assign pps_int = tick;
  assign rd_data = {{(DATA_W-STAT_W-1){1'b0}}, det, stat_s};

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ({gps_pwr, osc_en, ctrl_q.pps_oe, pps_sel, clk_sel} ==
               $past(wr_data[CTRL_W-1:0]))); // R2
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.pps_oe |-> !pps_out); // R7
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pps_sel == SRC_RSVD) |-> !pps_out); // R4
endmodule

// File: tb/sim_refpps_ctrl.sv
module sim_refpps_ctrl;
  localparam int TERM = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  pll_stat_in = '0;
  logic        pll_lock_in = 1'b0, pll_hold_in = 1'b0;
  logic        pps_ext_in = 1'b0, pps_gps_in = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  clk_sel, pps_sel;
  logic        pps_out, osc_en, gps_pwr, pps_int;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  refpps_ctrl #(.PPS_TERM(TERM)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pll_stat_in(pll_stat_in), .pll_lock_in(pll_lock_in), .pll_hold_in(pll_hold_in),
    .pps_ext_in(pps_ext_in), .pps_gps_in(pps_gps_in), .clk_sel(clk_sel),
    .pps_sel(pps_sel), .pps_out(pps_out), .osc_en(osc_en), .gps_pwr(gps_pwr),
    .pps_int(pps_int)
  );

  // behavioural reference model
  bit [6:0] m_ctrl = 7'h6A;
  bit       m_det = 0, m_sel = 0, m_last = 0, m_tick = 0;
  int       m_edges = 0;
  bit       ext_h[$];
  bit       gps_h[$];
  bit [3:0] st_h[$];
  bit       m_ext = 0, m_gps = 0;
  bit [3:0] m_st = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 7'h6A; m_det = 0; m_sel = 0; m_last = 0; m_tick = 0; m_edges = 0;
      ext_h.delete(); gps_h.delete(); st_h.delete();
      m_ext = 0; m_gps = 0; m_st = 0;
    end else begin
      if (m_sel && !m_last) m_det = !m_det;
      m_last = m_sel;
      if (wr_en) m_ctrl = wr_data[6:0];
      m_edges++;
      m_tick = (m_edges % TERM) == 0;
      ext_h.push_back(pps_ext_in);
      gps_h.push_back(pps_gps_in);
      st_h.push_back({pll_hold_in, pll_lock_in, pll_stat_in});
      if (ext_h.size() > 2) begin
        void'(ext_h.pop_front()); void'(gps_h.pop_front()); void'(st_h.pop_front());
      end
      m_ext = (ext_h.size() == 2) ? ext_h[0] : 1'b0;
      m_gps = (gps_h.size() == 2) ? gps_h[0] : 1'b0;
      m_st  = (st_h.size() == 2) ? st_h[0] : 4'h0;
      case (m_ctrl[3:2])
        2'd0: m_sel = m_ext;
        2'd2: m_sel = m_tick;
        2'd3: m_sel = m_gps;
        default: m_sel = 0;
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) if (!done) begin
    chk("R1/R2/R3 clk_sel", clk_sel, m_ctrl[1:0]);
    chk("R1/R2/R4 pps_sel", pps_sel, m_ctrl[3:2]);
    chk("R1/R2 osc_en", osc_en, m_ctrl[5]);
    chk("R1/R2 gps_pwr", gps_pwr, m_ctrl[6]);
    chk("R7/R9/R3 pps_out", pps_out, m_ctrl[4] & m_sel);
    chk("R8 pps_int", pps_int, m_tick);
    chk("R5 rd_data[3:0]", rd_data[3:0], m_st);
    chk("R6 rd_data[4]", rd_data[4], m_det);
    chk("R5 rd_data[31:5]", rd_data[31:5], 0);
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 32'hDEAD_BE80;
  endtask

  task automatic pulse_ext(int w);
    pps_ext_in = 1'b1; step(w); pps_ext_in = 1'b0; step(4);
  endtask

  task automatic pulse_gps(int w);
    pps_gps_in = 1'b1; step(w); pps_gps_in = 1'b0; step(4);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;                       // R1 reset state checked above
    step(25);                           // R8, R6: internal PPS drives detect
    pll_stat_in = 2'b10; pll_lock_in = 1'b1; step(3);   // R5
    pll_hold_in = 1'b1; pll_stat_in = 2'b01; step(3);
    wr(32'hFFFF_FF80 | 32'h30);         // R2: ext PPS, out enabled, high bits junk
    pulse_ext(1); pulse_ext(3); pulse_gps(2);           // R3, R9
    wr(32'h0000_005F);                  // GPS clock and PPS, out enabled
    pulse_gps(1); pulse_ext(2); pulse_gps(5);
    wr(32'h0000_0014);                  // R4 reserved code
    pulse_ext(2); pulse_gps(2); step(2 * TERM);
    pps_gps_in = 1'b1; wr(32'h0000_0010); step(3);      // ext selected, gps high
    wr(32'h0000_001C); step(4);         // R6 switch makes a rising edge
    pps_gps_in = 1'b0;
    pps_ext_in = 1'b1; step(1); wr(32'h0000_0010); pps_ext_in = 1'b0; step(4);
    wr(32'h0000_0008); step(2 * TERM);  // R7 output disabled, internal PPS
    wr(32'h0000_0042); pulse_ext(2); step(3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule